// File: doc/BRIEF.md
# PLL Clock-Source Enable Sequencer

This block sits between software-written control bits and the clock-steering logic of a device with an on-chip PLL. It holds three control bits: PLL power, main-clock source select and PWM-timer clock source select. It accepts a write to them only when the write respects a safe ordering. The PLL must be powered and must have finished a lock interval before either select may be raised. A select may be dropped only while the PWM timer is stopped. The PLL may be powered down only by its own write, once both selects are already low. A deep-sleep (halt) request is granted only when all three bits are low. The lock interval is modelled by a cycle counter whose length is a parameter.

A write that breaks a rule changes nothing, and it raises a sticky error flag. A halt request that arrives while the PLL is powered also raises that flag. Software clears the flag by pulsing the clear input. Each write carries a full new value for all three bits, so one write can touch several bits at the same time.

The control logic is a five-state machine:
- OFF: PLL unpowered.
- LOCKING: the lock counter is running.
- READY: locked, no select raised.
- SELECTED: at least one select is high.
- HALTED: halt granted.

Transitions:
- OFF to LOCKING on an accepted write that powers the PLL.
- OFF to HALTED on a halt request.
- LOCKING to READY when the counter expires.
- LOCKING to OFF, and READY to OFF, on an accepted power-down.
- READY to SELECTED on an accepted select raise.
- SELECTED to READY when an accepted write leaves both selects low.
- HALTED to LOCKING on an accepted power-up.
- HALTED to OFF when the request drops.

Top module: `clksrc_seq`

## Requirements
- R1: After reset, pll_on, sys_sel, pwm_sel, lock_done, halt_gnt and err_flag are all 0.
- R2: A write of 1 to bit 0 of ctl_wdata (PLL power) is accepted while the PLL is off. lock_done rises exactly LOCK_CYC clock cycles after the edge on which pll_on became 1.
- R3: A write that raises bit 1 (main-clock select) or bit 2 (PWM-clock select) while lock_done is 0 is rejected: no bit changes and err_flag becomes 1.
- R4: Once lock_done is 1, a write that keeps bit 0 at 1 and raises a select is accepted. sys_sel high means the main clock is taken from the PLL. A select is never high unless pll_on and lock_done are both high.
- R5: A write that lowers a select while pwm_run is 1 is rejected: the select stays high and err_flag becomes 1.
- R6: A write that lowers a select while pwm_run is 0 is accepted.
- R7: A write that lowers bit 0 while either select is high, or in the same write that lowers a select, is rejected with err_flag set.
- R8: A write that lowers bit 0 while both selects are low is accepted. lock_done falls on the same edge.
- R9: halt_gnt rises one cycle after halt_req is sampled high while all three bits are 0, and it stays high until halt_req drops. A halt_req sampled while pll_on is 1 grants nothing and sets err_flag.
- R10: err_flag holds until err_clr is sampled high. A new violation on the clearing edge keeps it at 1.
- R11: Powering the PLL from the halted state drops halt_gnt and times the full LOCK_CYC lock interval again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_wr | input | 1 | Write strobe for the control bits |
| ctl_wdata | input | 3 | New value: bit 0 PLL power, bit 1 main-clock select, bit 2 PWM-clock select |
| err_clr | input | 1 | Clears err_flag when high |
| pwm_run | input | 1 | PWM timer running status |
| halt_req | input | 1 | Halt request (level) |
| pll_on | output | 1 | PLL power control bit |
| sys_sel | output | 1 | Main clock taken from PLL |
| pwm_sel | output | 1 | PWM timer clock taken from PLL |
| lock_done | output | 1 | Lock interval complete |
| halt_gnt | output | 1 | Halt granted |
| err_flag | output | 1 | Sticky rule-violation flag |

## Verification
The bound checker watches the ordering invariants on every cycle:
- a select is never high without a completed lock;
- lock_done is never high without PLL power;
- a select never falls while the timer runs;
- power never falls with a select high;
- a grant only appears with all three bits low;
- the error flag stays sticky.

Some behaviour can only be shown by the bench's scenarios, which compare every output against a cycle-level reference model:
- the exact lock latency, including the repeated interval after halt;
- which writes are rejected;
- the precedence of a set over a clear on the error flag.

// File: rtl/clksrc_seq_pkg.sv
package clksrc_seq_pkg;

    typedef enum logic [2:0] {
        ST_OFF,
        ST_LOCKING,
        ST_READY,
        ST_SELECTED,
        ST_HALTED
    } seq_state_t;

    localparam int CTL_W   = 3;
    localparam int BIT_PLL = 0;
    localparam int BIT_SYS = 1;
    localparam int BIT_PWM = 2;

endpackage

// File: rtl/clksrc_wr_rules.sv
module clksrc_wr_rules
    import clksrc_seq_pkg::*;
(
    input  logic [CTL_W-1:0] cur_bits,
    input  logic [CTL_W-1:0] new_bits,
    input  logic             locked,
    input  logic             pwm_run,
    output logic             wr_legal
);
    logic raise_sel, lower_sel, lower_pll, any_sel;

    always_comb begin
        raise_sel = (new_bits[BIT_SYS] & ~cur_bits[BIT_SYS]) |
                    (new_bits[BIT_PWM] & ~cur_bits[BIT_PWM]);
        lower_sel = (~new_bits[BIT_SYS] & cur_bits[BIT_SYS]) |
                    (~new_bits[BIT_PWM] & cur_bits[BIT_PWM]);
        lower_pll = ~new_bits[BIT_PLL] & cur_bits[BIT_PLL];
        any_sel   = cur_bits[BIT_SYS] | cur_bits[BIT_PWM] |
                    new_bits[BIT_SYS] | new_bits[BIT_PWM];
        wr_legal  = 1'b1;
        if (raise_sel && !(locked && new_bits[BIT_PLL])) wr_legal = 1'b0;
        if (lower_sel && pwm_run)                        wr_legal = 1'b0;
        if (lower_pll && any_sel)                        wr_legal = 1'b0;
    end
endmodule

// File: rtl/clksrc_lock_timer.sv
module clksrc_lock_timer #(
    parameter int LOCK_CYC = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic counting,
    output logic expired
);
    localparam int CW = (LOCK_CYC > 1) ? $clog2(LOCK_CYC) : 1;
    localparam logic [CW-1:0] LAST = CW'(LOCK_CYC - 1);

    logic [CW-1:0] cnt_q;

    assign expired = counting && (cnt_q == LAST);

    always_ff @(posedge clk) begin
        if (!rst_n || !counting) begin
            cnt_q <= '0;
        end else if (!expired) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/clksrc_seq.sv
module clksrc_seq
    import clksrc_seq_pkg::*;
#(
    parameter int LOCK_CYC = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ctl_wr,
    input  logic [2:0] ctl_wdata,
    input  logic       err_clr,
    input  logic       pwm_run,
    input  logic       halt_req,
    output logic       pll_on,
    output logic       sys_sel,
    output logic       pwm_sel,
    output logic       lock_done,
    output logic       halt_gnt,
    output logic       err_flag
);
    seq_state_t        st_q, st_d;
    logic [CTL_W-1:0]  ctl_q;
    logic              err_q;
    logic              wr_legal, wr_acc, wr_rej, halt_bad, lock_expired;
    logic              locked;

    assign locked   = (st_q == ST_READY) || (st_q == ST_SELECTED);
    assign wr_acc   = ctl_wr && wr_legal;
    assign wr_rej   = ctl_wr && !wr_legal;
    assign halt_bad = halt_req && ctl_q[BIT_PLL];

    clksrc_wr_rules u_rules (
        .cur_bits (ctl_q),
        .new_bits (ctl_wdata),
        .locked   (locked),
        .pwm_run  (pwm_run),
        .wr_legal (wr_legal)
    );

    clksrc_lock_timer #(.LOCK_CYC(LOCK_CYC)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .counting (st_q == ST_LOCKING),
        .expired  (lock_expired)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_OFF;
        else        st_q <= st_d;
    end

    // next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_OFF: begin
                if (wr_acc && ctl_wdata[BIT_PLL]) st_d = ST_LOCKING;
                else if (halt_req)                st_d = ST_HALTED;
            end
            ST_LOCKING: begin
                if (wr_acc && !ctl_wdata[BIT_PLL]) st_d = ST_OFF;
                else if (lock_expired)             st_d = ST_READY;
            end
            ST_READY: begin
                if (wr_acc) begin
                    if (!ctl_wdata[BIT_PLL])                          st_d = ST_OFF;
                    else if (ctl_wdata[BIT_SYS] || ctl_wdata[BIT_PWM]) st_d = ST_SELECTED;
                end
            end
            ST_SELECTED: begin
                if (wr_acc && !ctl_wdata[BIT_SYS] && !ctl_wdata[BIT_PWM]) st_d = ST_READY;
            end
            ST_HALTED: begin
                if (wr_acc && ctl_wdata[BIT_PLL]) st_d = ST_LOCKING;
                else if (!halt_req)               st_d = ST_OFF;
            end
            default: st_d = ST_OFF;
        endcase
    end

    // control bits and error flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '0;
            err_q <= 1'b0;
        end else begin
            if (wr_acc) ctl_q <= ctl_wdata;
            err_q <= (err_q && !err_clr) || wr_rej || halt_bad;
        end
    end

    // outputs
    always_comb begin
        pll_on    = ctl_q[BIT_PLL];
        sys_sel   = ctl_q[BIT_SYS];
        pwm_sel   = ctl_q[BIT_PWM];
        lock_done = locked;
        halt_gnt  = (st_q == ST_HALTED);
        err_flag  = err_q;
    end
endmodule

// File: rtl/clksrc_seq_chk.sv
module clksrc_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic err_clr,
    input logic pwm_run,
    input logic pll_on,
    input logic sys_sel,
    input logic pwm_sel,
    input logic lock_done,
    input logic halt_gnt,
    input logic err_flag
);
    assert_sel_needs_lock_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (sys_sel || pwm_sel) |-> (pll_on && lock_done));

    assert_lock_needs_power_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !pll_on |-> !lock_done);

    assert_lock_rise_powered_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lock_done) |-> $past(pll_on));

    assert_sys_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (pwm_run && sys_sel) |=> sys_sel);

    assert_pwm_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (pwm_run && pwm_sel) |=> pwm_sel);

    assert_power_down_order_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pll_on) |-> ($past(!sys_sel && !pwm_sel) && !sys_sel && !pwm_sel));

    assert_halt_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        halt_gnt |-> (!pll_on && !sys_sel && !pwm_sel));

    assert_err_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (err_flag && !err_clr) |=> err_flag);
endmodule

bind clksrc_seq clksrc_seq_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .err_clr   (err_clr),
    .pwm_run   (pwm_run),
    .pll_on    (pll_on),
    .sys_sel   (sys_sel),
    .pwm_sel   (pwm_sel),
    .lock_done (lock_done),
    .halt_gnt  (halt_gnt),
    .err_flag  (err_flag)
);

// File: tb/clksrc_seq_tb_top.sv
module clksrc_seq_tb_top;
    localparam int LOCK = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ctl_wr = 1'b0;
    logic [2:0] ctl_wdata = '0;
    logic       err_clr = 1'b0;
    logic       pwm_run = 1'b0;
    logic       halt_req = 1'b0;
    logic       pll_on, sys_sel, pwm_sel, lock_done, halt_gnt, err_flag;

    int n_cmp = 0;
    int n_bad = 0;

    // reference model (state code: 0 off, 1 locking, 2 ready, 3 selected, 4 halted)
    int       m_st = 0;
    int       m_cnt = 0;
    logic [2:0] m_ctl = '0;
    logic     m_err = 1'b0;

    always #2.5 clk = ~clk;

    clksrc_seq #(.LOCK_CYC(LOCK)) dut_i (
        .clk, .rst_n, .ctl_wr, .ctl_wdata, .err_clr, .pwm_run, .halt_req,
        .pll_on, .sys_sel, .pwm_sel, .lock_done, .halt_gnt, .err_flag
    );

    function automatic logic m_locked();
        return (m_st == 2) || (m_st == 3);
    endfunction

    function automatic logic legal(logic [2:0] c, logic [2:0] n, logic lk, logic run);
        logic raise_s, lower_s, lower_p;
        raise_s = (n[1] && !c[1]) || (n[2] && !c[2]);
        lower_s = (!n[1] && c[1]) || (!n[2] && c[2]);
        lower_p = !n[0] && c[0];
        if (raise_s && !(lk && n[0])) return 1'b0;          // R3
        if (lower_s && run) return 1'b0;                    // R5
        if (lower_p && (c[1] || c[2] || n[1] || n[2])) return 1'b0; // R7
        return 1'b1;
    endfunction

    task automatic model_edge();
        logic ok, acc;
        int   nst;
        ok  = legal(m_ctl, ctl_wdata, m_locked(), pwm_run);
        acc = ctl_wr && ok;
        nst = m_st;
        case (m_st)
            0: if (acc && ctl_wdata[0]) nst = 1; else if (halt_req) nst = 4;
            1: if (acc && !ctl_wdata[0]) nst = 0; else if (m_cnt == LOCK - 1) nst = 2;
            2: if (acc) begin
                   if (!ctl_wdata[0]) nst = 0;
                   else if (ctl_wdata[1] || ctl_wdata[2]) nst = 3;
               end
            3: if (acc && !ctl_wdata[1] && !ctl_wdata[2]) nst = 2;
            default: if (acc && ctl_wdata[0]) nst = 1; else if (!halt_req) nst = 0;
        endcase
        m_cnt = (m_st == 1 && nst == 1) ? m_cnt + 1 : 0;
        m_err = (m_err && !err_clr) || (ctl_wr && !ok) || (halt_req && m_ctl[0]);
        if (acc) m_ctl = ctl_wdata;
        m_st = nst;
    endtask

    task automatic chk(input logic act, input logic exp, input string tag);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0b expected %0b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic cmp_all();
        chk(pll_on,    m_ctl[0],   "R2 R8 pll_on");
        chk(sys_sel,   m_ctl[1],   "R4 R5 R6 sys_sel");
        chk(pwm_sel,   m_ctl[2],   "R4 R5 R6 pwm_sel");
        chk(lock_done, m_locked(), "R2 R11 lock_done");
        chk(halt_gnt,  m_st == 4,  "R9 halt_gnt");
        chk(err_flag,  m_err,      "R10 err_flag");
    endtask

    task automatic step(input logic wr, input logic [2:0] wd, input logic clr,
                        input logic run, input logic hr);
        ctl_wr = wr; ctl_wdata = wd; err_clr = clr; pwm_run = run; halt_req = hr;
        @(posedge clk);
        model_edge();
        @(negedge clk);
        cmp_all();
    endtask

    task automatic idle(input int n, input logic run);
        for (int i = 0; i < n; i++) step(1'b0, 3'b000, 1'b0, run, 1'b0);
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        chk(pll_on | sys_sel | pwm_sel | lock_done | halt_gnt | err_flag, 1'b0, "R1 reset");
        // R3: select before lock
        step(1'b1, 3'b011, 1'b0, 1'b0, 1'b0);
        chk(sys_sel, 1'b0, "R3 early select"); chk(err_flag, 1'b1, "R3 err");
        step(1'b0, 3'b000, 1'b1, 1'b0, 1'b0);
        chk(err_flag, 1'b0, "R10 clear");
        // R2: lock latency
        step(1'b1, 3'b001, 1'b0, 1'b0, 1'b0);
        chk(pll_on, 1'b1, "R2 power");
        idle(LOCK - 1, 1'b0);
        chk(lock_done, 1'b0, "R2 before lock");
        step(1'b1, 3'b011, 1'b0, 1'b0, 1'b0);
        chk(sys_sel, 1'b0, "R3 one cycle early");
        chk(lock_done, 1'b1, "R2 lock at LOCK cycles");
        step(1'b0, 3'b000, 1'b1, 1'b0, 1'b0);
        // R4: accepted select
        step(1'b1, 3'b111, 1'b0, 1'b1, 1'b0);
        chk(sys_sel & pwm_sel, 1'b1, "R4 select");
        // R5: clear while timer runs
        step(1'b1, 3'b101, 1'b0, 1'b1, 1'b0);
        chk(sys_sel, 1'b1, "R5 held"); chk(err_flag, 1'b1, "R5 err");
        step(1'b0, 3'b000, 1'b1, 1'b0, 1'b0);
        // R7: power down with select clear in same write
        step(1'b1, 3'b000, 1'b0, 1'b0, 1'b0);
        chk(pll_on, 1'b1, "R7 power held"); chk(err_flag, 1'b1, "R7 err");
        step(1'b0, 3'b000, 1'b1, 1'b0, 1'b0);
        // R6: clear while timer stopped
        step(1'b1, 3'b001, 1'b0, 1'b0, 1'b0);
        chk(sys_sel | pwm_sel, 1'b0, "R6 cleared"); chk(err_flag, 1'b0, "R6 no err");
        // R9: halt while powered
        step(1'b0, 3'b000, 1'b0, 1'b0, 1'b1);
        chk(halt_gnt, 1'b0, "R9 no grant"); chk(err_flag, 1'b1, "R9 err");
        // R10: violation on clearing edge wins
        step(1'b0, 3'b000, 1'b1, 1'b0, 1'b1);
        chk(err_flag, 1'b1, "R10 set wins");
        // R8: power down
        step(1'b1, 3'b000, 1'b1, 1'b0, 1'b0);
        chk(pll_on | lock_done, 1'b0, "R8 off");
        // R9: grant
        step(1'b0, 3'b000, 1'b0, 1'b0, 1'b1);
        chk(halt_gnt, 1'b1, "R9 grant");
        step(1'b0, 3'b000, 1'b0, 1'b0, 1'b1);
        chk(halt_gnt, 1'b1, "R9 grant held");
        // R11: re-enable from halt
        step(1'b1, 3'b001, 1'b0, 1'b0, 1'b1);
        chk(halt_gnt, 1'b0, "R11 grant drop");
        idle(LOCK - 1, 1'b0);
        chk(lock_done, 1'b0, "R11 relock wait");
        idle(1, 1'b0);
        chk(lock_done, 1'b1, "R11 relocked");

        // constrained random phase
        void'($urandom(32'h5EED_0411));
        for (int i = 0; i < 4000; i++) begin
            logic run_r;
            run_r = ($urandom_range(99) < 30);
            step($urandom_range(99) < 35, 3'($urandom_range(7)),
                 $urandom_range(99) < 10, run_r, $urandom_range(99) < 12);
        end

        summary();
        $finish;
    end
endmodule